// File: doc/BRIEF.md
# Multi-Threshold Arrival-Time Comparator

This block turns the arrival time of one event pulse per sample period into a short digital word. A free-running tick counter divides time into periods of a programmable number of clock ticks. Within each period, an analog front end (outside this block) delivers a single event pulse. Its delay from the start of the period encodes the input level: the later the pulse, the larger the level.

Several race-arbiter cells (three by default) each own a programmable read tick. Each cell is set by the event. At its read tick the cell reports 1 if it has been set by then. An event that reaches a cell after that cell's read tick goes unreported, and the end-of-period clear discards it. A cell therefore fires when the event arrives at or before its read tick.

At the close of each period the block registers three things: the cell outputs as a thermometer word, a binary code equal to the number of cells that stayed silent, and a flag for a period with no event. It presents them with a one-cycle valid strobe.

Top module: `race_threshold_digitizer`

## Requirements
- R1: The tick counter runs from 0 to period_i-1 and then wraps, starting at 0 after reset (a period_i of 0 or 1 gives a one-tick period). valid_o pulses for one cycle in the cycle right after tick period_i-1, so it pulses exactly once per period.
- R2: Comparator i fires when the period's first event arrives on a tick t with t <= its read tick. An event on the read tick itself counts as arriving before the read.
- R3: An event that arrives after a comparator's read tick is not reported by it. The end-of-period clear discards it, so the next period starts with every comparator empty.
- R4: The read tick of comparator i is field thr_i[i*CNT_W +: CNT_W], and its result appears on therm_o[i]. Each read tick is set on its own; two or more may be equal.
- R5: When an event arrived, code_o equals N_CMP minus the number of set bits in therm_o (0 for the earliest arrivals, N_CMP for an event after every read tick).
- R6: A period with no event reports therm_o = 0, code_o = 0 and miss_o = 1. A period with an event reports miss_o = 0.
- R7: Only the first event in a period counts. Any further event in the same period has no effect on that period's result.
- R8: While valid_o is low, therm_o, code_o and miss_o are all 0. During and right after reset, all outputs are 0.
- R9: An event on the last tick of a period (tick period_i-1) is still seen. It fires any comparator whose read tick is period_i-1, and it clears the miss flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Tick clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| period_i | input | CNT_W | Period length in ticks |
| thr_i | input | N_CMP*CNT_W | Read ticks, field i for comparator i |
| event_i | input | 1 | Event pulse, sampled once per tick |
| valid_o | output | 1 | One-cycle result strobe |
| therm_o | output | N_CMP | Comparator results, bit i = comparator i |
| code_o | output | $clog2(N_CMP+1) | Count of comparators that did not fire |
| miss_o | output | 1 | No event arrived in the period |

## Verification
The checker relies on a few assumptions about the inputs:
- The read ticks are ordered, with field 0 the smallest and the last field the largest. The thermometer-shape property is gated on that ordering.
- The period length stays fixed within a period, which the tick-range property needs.
- Every read tick lies below the period length.

The scoreboard driver keeps within these assumptions. It changes period_i and thr_i only on tick 0, always supplies non-decreasing read ticks smaller than the period, and asserts event_i for whole ticks only. Multiple events, late events and empty periods are placed on purpose to reach R3, R6, R7 and R9.

// File: rtl/rtd_pkg.sv
package rtd_pkg;
  localparam int DEF_CNT_W = 8;
  localparam int DEF_N_CMP = 3;

  // bit i set implies bit i+1 set, for the low n bits of v
  function automatic logic is_thermo(input logic [31:0] v, input int n);
    for (int i = 0; i < n - 1; i++) begin
      if (v[i] && !v[i+1]) return 1'b0;
    end
    return 1'b1;
  endfunction
endpackage

// File: rtl/rtd_period_timer.sv
module rtd_period_timer #(
  parameter int CNT_W = rtd_pkg::DEF_CNT_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] period_i,
  output logic [CNT_W-1:0] tick_o,
  output logic             last_o
);
  logic [CNT_W-1:0] tick_q;

  // >= keeps the counter bounded if period shrinks
  assign last_o = (period_i <= CNT_W'(1)) || (tick_q >= period_i - CNT_W'(1));
  assign tick_o = tick_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     tick_q <= '0;
    else if (last_o) tick_q <= '0;
    else             tick_q <= tick_q + CNT_W'(1);
  end
endmodule

// File: rtl/rtd_event_gate.sv
module rtd_event_gate (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic event_i,
  input  logic last_i,
  output logic hit_o,
  output logic seen_o
);
  logic seen_q;

  assign hit_o  = event_i & ~seen_q;
  assign seen_o = seen_q | event_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      seen_q <= 1'b0;
    else if (last_i)  seen_q <= 1'b0;
    else if (event_i) seen_q <= 1'b1;
  end
endmodule

// File: rtl/rtd_src_cell.sv
module rtd_src_cell #(
  parameter int CNT_W = rtd_pkg::DEF_CNT_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] tick_i,
  input  logic [CNT_W-1:0] thr_i,
  input  logic             hit_i,
  input  logic             last_i,
  output logic             fire_o
);
  logic set_q, fire_q, read;

  assign read   = (tick_i == thr_i);
  // same-tick arrival wins the race against the read
  assign fire_o = fire_q | (read & (set_q | hit_i));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      set_q  <= 1'b0;
      fire_q <= 1'b0;
    end else if (last_i) begin
      set_q  <= 1'b0;
      fire_q <= 1'b0;
    end else begin
      set_q  <= set_q | hit_i;
      fire_q <= fire_o;
    end
  end
endmodule

// File: rtl/rtd_result_stage.sv
module rtd_result_stage #(
  parameter int N_CMP  = rtd_pkg::DEF_N_CMP,
  parameter int CODE_W = $clog2(N_CMP + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              last_i,
  input  logic              seen_i,
  input  logic [N_CMP-1:0]  fire_i,
  output logic              valid_o,
  output logic [N_CMP-1:0]  therm_o,
  output logic [CODE_W-1:0] code_o,
  output logic              miss_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      therm_o <= '0;
      code_o  <= '0;
      miss_o  <= 1'b0;
    end else if (last_i) begin
      valid_o <= 1'b1;
      therm_o <= seen_i ? fire_i : '0;
      code_o  <= seen_i ? CODE_W'(N_CMP - $countones(fire_i)) : '0;
      miss_o  <= ~seen_i;
    end else begin
      valid_o <= 1'b0;
      therm_o <= '0;
      code_o  <= '0;
      miss_o  <= 1'b0;
    end
  end
endmodule

// File: rtl/race_threshold_digitizer.sv
module race_threshold_digitizer #(
  parameter int CNT_W  = rtd_pkg::DEF_CNT_W,
  parameter int N_CMP  = rtd_pkg::DEF_N_CMP,
  parameter int CODE_W = $clog2(N_CMP + 1)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [CNT_W-1:0]       period_i,
  input  logic [N_CMP*CNT_W-1:0] thr_i,
  input  logic                   event_i,
  output logic                   valid_o,
  output logic [N_CMP-1:0]       therm_o,
  output logic [CODE_W-1:0]      code_o,
  output logic                   miss_o
);
  logic [CNT_W-1:0] tick_cnt;
  logic             last_tick, hit, seen;
  logic [N_CMP-1:0] fire;

  rtd_period_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i(clk_i), .rst_ni(rst_ni), .period_i(period_i),
    .tick_o(tick_cnt), .last_o(last_tick)
  );

  rtd_event_gate u_gate (
    .clk_i(clk_i), .rst_ni(rst_ni), .event_i(event_i), .last_i(last_tick),
    .hit_o(hit), .seen_o(seen)
  );

  for (genvar g = 0; g < N_CMP; g++) begin : g_cell
    rtd_src_cell #(.CNT_W(CNT_W)) u_cell (
      .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_cnt),
      .thr_i(thr_i[g*CNT_W +: CNT_W]), .hit_i(hit), .last_i(last_tick),
      .fire_o(fire[g])
    );
  end

  rtd_result_stage #(.N_CMP(N_CMP), .CODE_W(CODE_W)) u_result (
    .clk_i(clk_i), .rst_ni(rst_ni), .last_i(last_tick), .seen_i(seen),
    .fire_i(fire), .valid_o(valid_o), .therm_o(therm_o), .code_o(code_o),
    .miss_o(miss_o)
  );
endmodule

// File: rtl/rtd_checker.sv
module rtd_checker #(
  parameter int CNT_W  = rtd_pkg::DEF_CNT_W,
  parameter int N_CMP  = rtd_pkg::DEF_N_CMP,
  parameter int CODE_W = $clog2(N_CMP + 1)
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic [CNT_W-1:0]       period_i,
  input logic [N_CMP*CNT_W-1:0] thr_i,
  input logic [CNT_W-1:0]       tick_w,
  input logic                   valid_o,
  input logic [N_CMP-1:0]       therm_o,
  input logic [CODE_W-1:0]      code_o,
  input logic                   miss_o
);
  function automatic logic thr_ordered(input logic [N_CMP*CNT_W-1:0] t);
    for (int i = 0; i < N_CMP - 1; i++) begin
      if (t[i*CNT_W +: CNT_W] > t[(i+1)*CNT_W +: CNT_W]) return 1'b0;
    end
    return 1'b1;
  endfunction

  // R8
  idle_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> (therm_o == '0 && code_o == '0 && !miss_o));

  // R6
  miss_clean_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && miss_o) |-> (therm_o == '0 && code_o == '0));

  // R5
  code_match_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !miss_o) |-> (32'(code_o) == N_CMP - $countones(therm_o)));

  // R1
  valid_after_last_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (({1'b0, $past(tick_w)} + 1'b1 == {1'b0, $past(period_i)}) ||
                 ($past(period_i) <= CNT_W'(1) && $past(tick_w) == '0)));

  // R1
  tick_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($stable(period_i) && period_i > CNT_W'(1)) |-> (tick_w < period_i));

  // R2
  thermo_shape_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && thr_ordered(thr_i)) |-> rtd_pkg::is_thermo(32'(therm_o), N_CMP));
endmodule

bind race_threshold_digitizer rtd_checker #(.CNT_W(CNT_W), .N_CMP(N_CMP), .CODE_W(CODE_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .period_i(period_i), .thr_i(thr_i),
  .tick_w(tick_cnt), .valid_o(valid_o), .therm_o(therm_o), .code_o(code_o),
  .miss_o(miss_o)
);

// File: tb/race_threshold_digitizer_bench.sv
module race_threshold_digitizer_bench;
  localparam int CNT_W = 8;
  localparam int N_CMP = 3;
  localparam int CODE_W = 2;

  typedef struct {
    logic [N_CMP-1:0]  therm;
    logic [CODE_W-1:0] code;
    logic              miss;
    string             tag;
  } exp_t;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic [CNT_W-1:0] period_i = 8'd10;
  logic [N_CMP*CNT_W-1:0] thr_i = '0;
  logic event_i = 1'b0;
  logic valid_o, miss_o;
  logic [N_CMP-1:0] therm_o;
  logic [CODE_W-1:0] code_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  exp_t q[$];

  always #4 clk_i = ~clk_i;

  race_threshold_digitizer #(.CNT_W(CNT_W), .N_CMP(N_CMP)) u_race_threshold_digitizer (
    .clk_i(clk_i), .rst_ni(rst_ni), .period_i(period_i), .thr_i(thr_i),
    .event_i(event_i), .valid_o(valid_o), .therm_o(therm_o), .code_o(code_o),
    .miss_o(miss_o)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  // driver: one full period, entered and left on a falling edge at tick 0
  task automatic run_period(input int p, input int t1, input int t2, input int t3,
                            input int e0, input int e1, input string tag);
    exp_t e;
    int first;
    int thr[3];
    int ones;
    period_i = CNT_W'(p);
    thr_i = {CNT_W'(t3), CNT_W'(t2), CNT_W'(t1)};
    thr[0] = t1; thr[1] = t2; thr[2] = t3;
    first = -1;
    if (e0 >= 0 && e0 < p) first = e0;
    if (e1 >= 0 && e1 < p && (first < 0 || e1 < first)) first = e1;
    ones = 0;
    for (int i = 0; i < N_CMP; i++) begin
      e.therm[i] = (first >= 0) && (first <= thr[i]);
      if (e.therm[i]) ones++;
    end
    e.miss = (first < 0);
    e.code = e.miss ? '0 : CODE_W'(N_CMP - ones);
    e.tag = tag;
    for (int tk = 0; tk < p; tk++) begin
      event_i = (tk == e0) || (tk == e1);
      @(posedge clk_i);
      if (tk == p - 1) q.push_back(e);
      @(negedge clk_i);
    end
    event_i = 1'b0;
  endtask

  // monitor / scoreboard
  initial begin
    exp_t it;
    forever begin
      @(negedge clk_i);
      if (rst_ni) begin
        if (q.size() > 0) begin
          it = q.pop_front();
          chk(valid_o === 1'b1, {"R1 ", it.tag}, "valid", int'(valid_o), 1);
          chk(therm_o === it.therm, it.tag, "therm", int'(therm_o), int'(it.therm));
          chk(code_o === it.code, {"R5 ", it.tag}, "code", int'(code_o), int'(it.code));
          chk(miss_o === it.miss, {"R6 ", it.tag}, "miss", int'(miss_o), int'(it.miss));
        end else begin
          chk(valid_o === 1'b0, "R1", "stray valid", int'(valid_o), 0);
          chk(therm_o === '0 && code_o === '0 && miss_o === 1'b0, "R8",
              "idle outputs", int'({therm_o, code_o, miss_o}), 0);
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (100000) @(posedge clk_i);
    chk(1'b0, "R1", "watchdog expired", 1, 0);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R8 reset state
    chk(valid_o === 1'b0 && therm_o === '0 && code_o === '0 && miss_o === 1'b0,
        "R8", "reset outputs", int'({valid_o, therm_o, code_o, miss_o}), 0);
    rst_ni = 1'b1;
    // R2 basic arrivals, thresholds 2,5,8
    run_period(10, 2, 5, 8, 0, -1, "R2 early");
    run_period(10, 2, 5, 8, 2, -1, "R2 same tick");
    run_period(10, 2, 5, 8, 3, -1, "R2 after first");
    run_period(10, 2, 5, 8, 6, -1, "R2 after second");
    run_period(10, 2, 5, 8, 8, -1, "R2 on last read");
    // R3 late event then empty period must stay empty
    run_period(10, 2, 5, 8, 9, -1, "R3 late");
    run_period(10, 2, 5, 8, -1, -1, "R3 R6 cleared");
    // R7 second event ignored
    run_period(10, 2, 5, 8, 7, 1, "R7 second ignored");
    run_period(10, 2, 5, 8, 4, 5, "R7 back to back");
    // R4 independent thresholds
    run_period(10, 0, 0, 9, 0, -1, "R4 equal low");
    run_period(10, 0, 0, 9, 1, -1, "R4 only top");
    run_period(10, 3, 7, 7, 7, -1, "R4 equal high");
    // R9 last-tick event
    run_period(10, 9, 9, 9, 9, -1, "R9 last tick read");
    run_period(10, 2, 5, 8, 9, -1, "R9 last tick late");
    // R1 period changes
    run_period(4, 1, 2, 3, 2, -1, "R1 short period");
    run_period(1, 0, 0, 0, 0, -1, "R1 one tick");
    run_period(1, 0, 0, 0, -1, -1, "R1 R6 one tick empty");
    run_period(200, 50, 100, 150, 120, -1, "R1 long period");
    // R2 R5 sweep
    for (int t = -1; t < 6; t++) run_period(6, 1, 3, 4, t, -1, "R2 R5 sweep");
    @(negedge clk_i);
    chk(q.size() == 0, "R1", "pending results", q.size(), 0);
    finish_run();
  end
endmodule